// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz time-base enable into a periodic tick whose rate comes from a 4-bit rate code. A free-running 15-bit prescaler counts time-base pulses. The rate code picks how many of its low bits must all be ones for a tick to fire. Every tick sets a sticky periodic-interrupt flag. The interrupt output is driven while that flag is set and the periodic-interrupt enable is high. Software clears the flag with a one-cycle strobe.

The mapping from code to rate is not linear. Code 0 turns the tick off. Codes 1 and 2 alias onto the rates of codes 8 and 9. From code 3 (8192 Hz) up to code 15 (2 Hz), each step halves the frequency. The reset default used by software is code 6, which gives 1024 Hz.

While the prescaler hold input is high, the counter is kept at zero and no tick is produced. Releasing the hold restarts the tick phase, so the first tick comes one full period after release.

Top module: `pit_rate_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `tick`, `pi_flag` and `irq` are 0 and the prescaler is zero.
- R2: The prescaler advances only on cycles where `tb_en` is high, so tick spacing is counted in `tb_en` pulses and not in clock cycles.
- R3: For a rate code c from 3 to 15, ticks come every 2^(c-1) `tb_en` pulses. Code 3 gives 4 pulses (8192 Hz), code 6 gives 32 pulses (1024 Hz) and code 15 gives 16384 pulses (2 Hz).
- R4: Code 1 gives a period of 128 pulses and code 2 gives 256 pulses. These equal the periods of codes 8 and 9.
- R5: Rate code 0 never produces a tick.
- R6: While `div_hold` is high, the prescaler is held at zero and no tick occurs. After release, the first tick follows one full period of the selected code.
- R7: A change of rate code does not restart the prescaler. The new code takes effect at its next boundary, which is the next point where its selected low bits are all ones.
- R8: `pi_flag` is set in the same cycle as `tick` and stays set until a `flag_clr` strobe. If a tick and a clear happen together, the set wins.
- R9: `irq` is high exactly when `pi_flag` and `pi_en` are both high.
- R10: `tick` is a single-cycle pulse. It rises in the cycle after the clock edge at which the `tb_en` pulse that completes the period is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_en | input | 1 | 32768 Hz time-base enable, one clock wide |
| div_hold | input | 1 | Holds the prescaler at zero while high |
| rate_sel | input | 4 | Rate code: 0 = off, 1 and 2 alias onto 8 and 9, 3 to 15 halve the rate per step |
| pi_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the periodic flag |
| tick | output | 1 | One-cycle periodic tick pulse |
| pi_flag | output | 1 | Sticky periodic-interrupt flag |
| irq | output | 1 | Interrupt request, flag AND enable |

## Verification
Assertions check the cycle-level rules on every cycle. These are: the prescaler steps by one on each enable and stays put without one, the hold forces it to zero, code 0 and the hold suppress ticks, a tick always comes with the flag, the flag persists until cleared, and a tick never lasts two cycles. The tick periods, the aliasing of codes 1 and 2, the effect of a code change in mid-count and set-over-clear priority depend on long sequences. Only the bench scenarios show these, by counting the pulses between ticks against expected periods.

// File: rtl/pit_pkg.sv
// Package: shared helpers for the periodic interrupt rate generator.
// Assumes rate codes are unsigned and that code 0 means "off".
package pit_pkg;

    // Number of low prescaler bits that must all be one for a tick.
    // Zero means the tick is disabled.
    function automatic int unsigned pit_sel_bits(
        input int unsigned code,
        input int unsigned first_code,
        input int unsigned alias_add
    );
        if (code == 0)
            return 0;
        else if (code < first_code)
            return code + alias_add - 1;
        else
            return code - 1;
    endfunction

endpackage

// File: rtl/pit_rate_decode.sv
// Module: pit_rate_decode
// Turns the rate code into a mask of prescaler low bits and an active flag.
// Assumes the largest selected width fits inside CNT_W bits.
module pit_rate_decode #(
    parameter int CODE_W     = 4,
    parameter int CNT_W      = 15,
    parameter int FIRST_CODE = 3,
    parameter int ALIAS_ADD  = 7
) (
    input  logic [CODE_W-1:0] rate_sel,
    output logic [CNT_W-1:0]  sel_mask,
    output logic              sel_active
);
    import pit_pkg::*;

    int unsigned sel_bits;

    // Width of the selected counter slice for the current code.
    always_comb begin
        sel_bits = pit_sel_bits(int'(rate_sel), FIRST_CODE, ALIAS_ADD);
    end

    // Each mask bit is set when its position lies inside the selected slice.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign sel_mask[i] = (i < int'(sel_bits));
    end

    // The tick is disabled for code 0.
    assign sel_active = (rate_sel != '0);

endmodule

// File: rtl/pit_prescaler.sv
// Module: pit_prescaler
// Free-running prescaler driven by the time-base enable.
// It raises a strobe when the selected low bits are all ones on an enable.
// Assumes tb_en is a one-clock pulse and that hold overrides counting.
module pit_prescaler #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_en,
    input  logic             hold,
    input  logic [CNT_W-1:0] sel_mask,
    input  logic             sel_active,
    output logic [CNT_W-1:0] cnt,
    output logic             strobe
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Counter: reset or hold clears it, and each enable steps it by one.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            cnt <= '0;
        else if (tb_en)
            cnt <= cnt + CNT_ONE;
    end

    // Strobe when this enable completes the selected period.
    always_comb begin
        strobe = tb_en && !hold && sel_active && ((cnt & sel_mask) == sel_mask);
    end

    // R6: the hold forces the prescaler to zero.
    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0));

    // R2: each enable advances the prescaler by exactly one.
    assert_step_on_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_en && !hold) |=> (cnt == CNT_W'($past(cnt) + CNT_ONE)));

    // R2: without an enable the prescaler keeps its value.
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_en && !hold) |=> $stable(cnt));

endmodule

// File: rtl/pit_flag.sv
// Module: pit_flag
// Registers the tick, keeps the sticky periodic flag and forms the interrupt.
// Assumes a set and a clear in the same cycle resolve in favour of the set.
module pit_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic flag_clr,
    input  logic pi_en,
    output logic tick,
    output logic pi_flag,
    output logic irq
);
    // Tick register: a one-cycle copy of the prescaler strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick <= 1'b0;
        else
            tick <= strobe;
    end

    // Flag register: the set takes priority over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pi_flag <= 1'b0;
        else if (strobe)
            pi_flag <= 1'b1;
        else if (flag_clr)
            pi_flag <= 1'b0;
    end

    // Interrupt line: the flag gated by the enable.
    assign irq = pi_flag && pi_en;

    // R8: the flag stays set until a clear arrives.
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pi_flag && !flag_clr) |=> pi_flag);

    // R8: the flag is set whenever a tick is shown.
    assert_tick_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> pi_flag);

endmodule

// File: rtl/pit_rate_gen.sv
// Module: pit_rate_gen (top)
// Periodic interrupt rate generator. A 15-bit prescaler runs on a 32768 Hz
// enable and a 4-bit rate code picks the tick period. Ticks set a sticky
// flag, and the flag drives irq when it is enabled.
// Assumes tb_en is synchronous to clk and one clock wide.
module pit_rate_gen #(
    parameter int CODE_W     = 4,
    parameter int CNT_W      = 15,
    parameter int FIRST_CODE = 3,
    parameter int ALIAS_ADD  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_en,
    input  logic              div_hold,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              pi_en,
    input  logic              flag_clr,
    output logic              tick,
    output logic              pi_flag,
    output logic              irq
);
    logic [CNT_W-1:0] sel_mask;
    logic             sel_active;
    logic [CNT_W-1:0] cnt;
    logic             strobe;

    pit_rate_decode #(
        .CODE_W    (CODE_W),
        .CNT_W     (CNT_W),
        .FIRST_CODE(FIRST_CODE),
        .ALIAS_ADD (ALIAS_ADD)
    ) u_decode (
        .rate_sel  (rate_sel),
        .sel_mask  (sel_mask),
        .sel_active(sel_active)
    );

    pit_prescaler #(
        .CNT_W(CNT_W)
    ) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .tb_en     (tb_en),
        .hold      (div_hold),
        .sel_mask  (sel_mask),
        .sel_active(sel_active),
        .cnt       (cnt),
        .strobe    (strobe)
    );

    pit_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .flag_clr(flag_clr),
        .pi_en   (pi_en),
        .tick    (tick),
        .pi_flag (pi_flag),
        .irq     (irq)
    );

    // R5: code 0 never yields a tick.
    assert_code0_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> !tick);

    // R6: no tick while the prescaler is held.
    assert_hold_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        div_hold |=> !tick);

    // R10: a tick lasts one cycle.
    assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R1: the tick is low in the cycle after a reset edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tick && !pi_flag));

endmodule

// File: tb/pit_rate_gen_tb_top.sv
module pit_rate_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    localparam logic [3:0] V_CODE [NVEC] = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
                                            4'd1, 4'd8, 4'd2, 4'd9, 4'd15};
    localparam int V_PER [NVEC] = '{4, 8, 16, 32, 64, 128, 128, 256, 256, 16384};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_en = 1'b0;
    logic       div_hold = 1'b0;
    logic [3:0] rate_sel = 4'd6;
    logic       pi_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       tick, pi_flag, irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_rate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .div_hold(div_hold),
        .rate_sel(rate_sel), .pi_en(pi_en), .flag_clr(flag_clr),
        .tick(tick), .pi_flag(pi_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Hold the prescaler for one edge with the flag cleared, then release.
    task automatic restart(input logic [3:0] code);
        rate_sel = code;
        tb_en = 1'b1;
        div_hold = 1'b1;
        flag_clr = 1'b1;
        step();
        div_hold = 1'b0;
        flag_clr = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int first_t, second_t, nticks;
        // R1: reset state
        repeat (3) step();
        chk(tick == 0 && pi_flag == 0 && irq == 0, "R1 reset outputs", {tick, pi_flag, irq}, 0);
        rst_n = 1'b1;

        // R3/R4: table of codes and periods, two periods each
        for (int v = 0; v < NVEC; v++) begin
            restart(V_CODE[v]);
            first_t = 0; second_t = 0; nticks = 0;
            for (int n = 1; n <= 2 * V_PER[v] + 1; n++) begin
                step();
                if (tick) begin
                    nticks++;
                    if (nticks == 1) first_t = n;
                    if (nticks == 2) second_t = n;
                end
            end
            chk(first_t == V_PER[v], (V_CODE[v] < 3) ? "R4 first tick" : "R3 first tick",
                first_t, V_PER[v]);
            chk(second_t == 2 * V_PER[v], (V_CODE[v] < 3) ? "R4 second tick" : "R3 second tick",
                second_t, 2 * V_PER[v]);
            chk(nticks == 2, "R10 tick count", nticks, 2);
            chk(pi_flag == 1, "R8 flag set by tick", pi_flag, 1);
        end

        // R5: code 0 never ticks
        restart(4'd0);
        nticks = 0;
        for (int n = 0; n < 20000; n++) begin
            step();
            if (tick) nticks++;
        end
        chk(nticks == 0, "R5 code 0 ticks", nticks, 0);
        chk(pi_flag == 0, "R5 code 0 flag", pi_flag, 0);

        // R6: hold suppresses ticks; first tick one period after release
        rate_sel = 4'd3;
        div_hold = 1'b1;
        flag_clr = 1'b1;
        nticks = 0;
        for (int n = 0; n < 40; n++) begin
            step();
            if (tick) nticks++;
        end
        chk(nticks == 0, "R6 ticks under hold", nticks, 0);
        div_hold = 1'b0;
        flag_clr = 1'b0;
        first_t = 0;
        for (int n = 1; n <= 4; n++) begin
            step();
            if (tick && first_t == 0) first_t = n;
        end
        chk(first_t == 4, "R6 first tick after release", first_t, 4);

        // R2: sparse enable, code 3, tick after 4 enables (edge 7)
        restart(4'd3);
        first_t = 0;
        for (int n = 1; n <= 8; n++) begin
            tb_en = n[0];
            step();
            if (tick && first_t == 0) first_t = n;
        end
        chk(first_t == 7, "R2 sparse enable tick edge", first_t, 7);
        tb_en = 1'b1;

        // R7: code 6 for 10 edges, then code 3: tick at edge 12
        restart(4'd6);
        nticks = 0;
        for (int n = 1; n <= 10; n++) begin
            step();
            if (tick) nticks++;
        end
        rate_sel = 4'd3;
        step();
        chk(tick == 0 && nticks == 0, "R7 no tick before boundary", tick, 0);
        step();
        chk(tick == 1, "R7 tick at new boundary", tick, 1);

        // R8: set wins over simultaneous clear (code 3, tick at edge 4)
        restart(4'd3);
        step(); step(); step();
        flag_clr = 1'b1;
        step();
        chk(pi_flag == 1 && tick == 1, "R8 set beats clear", pi_flag, 1);
        step();
        chk(pi_flag == 0, "R8 clear strobe", pi_flag, 0);
        flag_clr = 1'b0;

        // R9: irq gating, with the flag held by stopping the enable
        restart(4'd3);
        repeat (4) step();
        tb_en = 1'b0;
        pi_en = 1'b0;
        step();
        chk(pi_flag == 1 && irq == 0, "R9 irq masked", irq, 0);
        pi_en = 1'b1;
        #1;
        chk(irq == 1, "R9 irq enabled", irq, 1);
        repeat (5) step();
        chk(pi_flag == 1, "R8 flag sticky", pi_flag, 1);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(irq == 0 && pi_flag == 0, "R9 irq after clear", irq, 0);

        // R1: reset in mid-run clears the flag
        restart(4'd3);
        repeat (4) step();
        rst_n = 1'b0;
        step();
        chk(pi_flag == 0 && tick == 0, "R1 reset mid-run", pi_flag, 0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule